// File: doc/BRIEF.md
# Fractional Microsecond Tick Generator

This block turns a reference clock of almost any frequency into a stream of single-cycle ticks whose long-run average rate is 1 MHz, and it counts those ticks in a free-running microsecond counter. The ratio is rational, not integer. A 16-bit configuration word gives a numerator (ticks) and a denominator (reference cycles), each stored as its value minus one. Within any span of denominator cycles, the block spreads numerator ticks as evenly as it can. Because the ratio is rational, references such as 12.8 MHz (5 ticks per 64 cycles) or 38.4 MHz (5 ticks per 192 cycles) still give an exact 1 MHz average. Integer references such as 12, 13, 26 or 48 MHz use a numerator of one.

Software reaches the block through a simple single-cycle register port. A write with the configuration address loads a new ratio and restarts the phase of the fraction, while the counter keeps its value. A read is combinational and returns either the configuration word or the counter. The tick output goes straight to the timer channels that need a microsecond time base. Inside, an accumulator adds the numerator on every cycle. When the sum reaches the denominator, the accumulator subtracts the denominator and fires a tick.

Top module: `usec_tick_gen`

## Requirements
- R1: While reset is asserted and right after it is released, the tick output is low, the counter reads 0 and the configuration word reads 0x000B (one tick per 12 cycles).
- R2: The configuration word sits at byte offset 0x14. Bits [7:0] hold the cycle field (reference cycles minus one) and bits [15:8] hold the tick field (ticks minus one). A read returns these 16 bits with every higher bit zero, and write data above bit 15 is discarded.
- R3: Let N = tick field + 1 and D = cycle field + 1, with N < D. After the j-th rising edge that follows a configuration write or the release of reset, the total number of ticks since that point is exactly floor(j*N/D), and each tick lasts a single cycle.
- R4: The counter reads at byte offset 0x10. It increases by one on the edge after each cycle in which the tick is high and holds otherwise. It wraps modulo 2^CNT_W and reads zero-extended to the data width.
- R5: In the cycle after a configuration write the tick is low and the fraction restarts from zero phase. The counter value is not disturbed.
- R6: When N >= D the tick is high in every cycle that does not follow a configuration write.
- R7: Writes to the counter address or to any address other than 0x14 have no effect on the configuration, the counter or the tick sequence. A read from any address other than 0x10 or 0x14 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | ADDR_W (8) | Byte address for read and write |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Combinational read data for `addr` |
| tick_o | output | 1 | Single-cycle microsecond tick |

## Verification
The bench builds the block with an 8-bit counter (CNT_W = 8), so that counter wrap-around and the zero-extended read path come within a few hundred ticks. The 8-bit configuration fields stay at their default width, so every reference ratio in the requirements can be programmed. These include the integer ratios, the 5-per-64, 5-per-96 and 5-per-192 fractions, divide-by-one and the saturated case with N above D. Seeded random ratios across the full field range are also applied. Every cycle is compared with the floor(j*N/D) staircase.

// File: rtl/utg_pkg.sv
package utg_pkg;

   // Read source selected by the address decoder
   typedef enum logic [1:0] {
      RD_NONE = 2'd0,
      RD_CFG  = 2'd1,
      RD_CNT  = 2'd2
   } utg_rd_sel_e;

   // Next-state decision of the fractional accumulator
   typedef enum logic [1:0] {
      ACC_HOLD_PHASE = 2'd0,
      ACC_FIRE       = 2'd1,
      ACC_SATURATE   = 2'd2,
      ACC_RESTART    = 2'd3
   } utg_acc_step_e;

   function automatic utg_rd_sel_e utg_decode
      (input logic hit_cfg, input logic hit_cnt);
      if (hit_cfg)      return RD_CFG;
      else if (hit_cnt) return RD_CNT;
      else              return RD_NONE;
   endfunction

endpackage

// File: rtl/utg_regs.sv
module utg_regs #(
   parameter int FIELD_W = 8,
   parameter int ADDR_W  = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h14,
   parameter logic [2*FIELD_W-1:0] CFG_RESET = 16'h000B
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [2*FIELD_W-1:0] wfield,
   output logic [FIELD_W-1:0]   tick_fld_o,
   output logic [FIELD_W-1:0]   cyc_fld_o,
   output logic                 cfg_wr_o
);
   localparam int CFG_W = 2 * FIELD_W;

   logic [CFG_W-1:0] cfg_q;

   assign cfg_wr_o = wr_en && (addr == CFG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q <= CFG_RESET;
      else if (cfg_wr_o) cfg_q <= wfield;
   end

   assign cyc_fld_o  = cfg_q[FIELD_W-1:0];
   assign tick_fld_o = cfg_q[CFG_W-1:FIELD_W];

   // The configuration changes only through a write to its own address
   assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == CFG_ADDR) |=> $stable(cfg_q));

endmodule

// File: rtl/utg_rate_acc.sv
module utg_rate_acc
   import utg_pkg::*;
#(
   parameter int FIELD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_i,
   input  logic [FIELD_W-1:0] tick_fld_i,
   input  logic [FIELD_W-1:0] cyc_fld_i,
   output logic               tick_o
);
   localparam int ACC_W = FIELD_W + 2;

   logic [ACC_W-1:0] num, den, acc_q, sum;
   logic             sat;
   logic             tick_q;
   utg_acc_step_e    step;

   assign num = ACC_W'(tick_fld_i) + ACC_W'(1);
   assign den = ACC_W'(cyc_fld_i) + ACC_W'(1);
   assign sum = acc_q + num;
   assign sat = (num >= den);

   always_comb begin
      if (clr_i)           step = ACC_RESTART;
      else if (sat)        step = ACC_SATURATE;
      else if (sum >= den) step = ACC_FIRE;
      else                 step = ACC_HOLD_PHASE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         unique case (step)
            ACC_RESTART: begin
               acc_q  <= '0;
               tick_q <= 1'b0;
            end
            ACC_SATURATE: begin
               acc_q  <= '0;
               tick_q <= 1'b1;
            end
            ACC_FIRE: begin
               acc_q  <= sum - den;
               tick_q <= 1'b1;
            end
            default: begin
               acc_q  <= sum;
               tick_q <= 1'b0;
            end
         endcase
      end
   end

   assign tick_o = tick_q;

   // Residual phase always stays below the denominator
   assert_acc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < den);

   // A configuration write silences the next cycle
   assert_quiet_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !tick_o);

   // Saturated ratio ticks every cycle
   assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && sat) |=> tick_o);

endmodule

// File: rtl/utg_counter.sv
module utg_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt_o = cnt_q;

   assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

   assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/usec_tick_gen.sv
module usec_tick_gen
   import utg_pkg::*;
#(
   parameter int FIELD_W = 8,
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter logic [ADDR_W-1:0] CNT_ADDR = 8'h10,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h14,
   parameter logic [2*FIELD_W-1:0] CFG_RESET = 16'h000B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              tick_o
);
   localparam int CFG_W = 2 * FIELD_W;

   // Elaboration-time parameter checks
   if (FIELD_W < 1)        $error("FIELD_W must be at least 1");
   if (CNT_W < 1)          $error("CNT_W must be at least 1");
   if (DATA_W < CFG_W)     $error("DATA_W must hold the configuration word");
   if (DATA_W < CNT_W)     $error("DATA_W must hold the counter");
   if (CFG_ADDR == CNT_ADDR) $error("register addresses must differ");

   logic [FIELD_W-1:0] tick_fld, cyc_fld;
   logic               cfg_wr;
   logic [CNT_W-1:0]   cnt;
   logic [DATA_W-1:0]  cfg_ext, cnt_ext;
   utg_rd_sel_e        rd_sel;

   utg_regs #(
      .FIELD_W  (FIELD_W),
      .ADDR_W   (ADDR_W),
      .CFG_ADDR (CFG_ADDR),
      .CFG_RESET(CFG_RESET)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wfield    (wdata[CFG_W-1:0]),
      .tick_fld_o(tick_fld),
      .cyc_fld_o (cyc_fld),
      .cfg_wr_o  (cfg_wr)
   );

   utg_rate_acc #(
      .FIELD_W(FIELD_W)
   ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (cfg_wr),
      .tick_fld_i(tick_fld),
      .cyc_fld_i (cyc_fld),
      .tick_o    (tick_o)
   );

   utg_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick_i(tick_o),
      .cnt_o (cnt)
   );

   // Width adaptation of the read sources
   if (DATA_W > CFG_W) begin : g_cfg_pad
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata[DATA_W-1:CFG_W];
      assign cfg_ext = {{(DATA_W-CFG_W){1'b0}}, tick_fld, cyc_fld};
   end else begin : g_cfg_full
      assign cfg_ext = {tick_fld, cyc_fld};
   end

   if (DATA_W > CNT_W) begin : g_cnt_pad
      assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, cnt};
   end else begin : g_cnt_full
      assign cnt_ext = cnt;
   end

   assign rd_sel = utg_decode(addr == CFG_ADDR, addr == CNT_ADDR);

   always_comb begin
      unique case (rd_sel)
         RD_CFG:  rdata = cfg_ext;
         RD_CNT:  rdata = cnt_ext;
         default: rdata = '0;
      endcase
   end

   assert_rd_decode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != CFG_ADDR && addr != CNT_ADDR) |-> (rdata == '0));

endmodule

// File: tb/usec_tick_gen_test.sv
module usec_tick_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 8;
   localparam logic [7:0] A_CNT = 8'h10;
   localparam logic [7:0] A_CFG = 8'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = A_CNT;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        tick_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   longint cur_n = 1, cur_d = 12, jcyc = 0, model_cnt = 0;
   logic [15:0] cur_cfg = 16'h000B;

   always #(CLK_PERIOD/2) clk = ~clk;

   usec_tick_gen #(.CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tick_o(tick_o)
   );

   function automatic logic exp_tick(longint j, longint n, longint d);
      if (j == 0) return 1'b0;
      if (n >= d) return 1'b1;
      return ((j * n) / d) != (((j - 1) * n) / d);
   endfunction

   task automatic check(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One cycle: compare tick with the staircase and the counter with the model
   task automatic step(bit chk_cfg);
      logic e;
      @(negedge clk);
      jcyc++;
      e = exp_tick(jcyc, cur_n, cur_d);
      check((cur_n >= cur_d) ? "R6 tick" : "R3 tick", tick_o, e);
      if (chk_cfg) begin
         addr = A_CFG; #1;
         check("R2 cfg readback", rdata, {16'h0, cur_cfg});
         addr = A_CNT;
      end
      #1;
      check("R4 counter", rdata, model_cnt % (1 << CNT_W));
      model_cnt += e;
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step(i == n - 1);
   endtask

   // Register write issued at a falling edge, effective at the next rising edge
   task automatic wr(logic [7:0] a, logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = A_CNT;
      if (a == A_CFG) begin
         cur_cfg = d[15:0];
         cur_n = longint'(d[15:8]) + 1;
         cur_d = longint'(d[7:0]) + 1;
         jcyc = 0;
         #1;
         check("R5 tick low after write", tick_o, 0);
         check("R5 counter kept", rdata, model_cnt % (1 << CNT_W));
         model_cnt += 0;
      end else begin
         jcyc++;
         #1;
         check("R7 tick unaffected", tick_o, exp_tick(jcyc, cur_n, cur_d));
         check("R7 counter unaffected", rdata, model_cnt % (1 << CNT_W));
         model_cnt += exp_tick(jcyc, cur_n, cur_d);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      logic [7:0] lo, hi;
      seed = $urandom(32'h1A2B3C4D);
      // R1: reset state
      repeat (3) @(negedge clk);
      addr = A_CNT; #1;
      check("R1 tick in reset", tick_o, 0);
      check("R1 counter in reset", rdata, 0);
      addr = A_CFG; #1;
      check("R1 cfg in reset", rdata, 32'h0000_000B);
      addr = A_CNT;
      rst_n = 1'b1;  // released at a falling edge, acc phase zero
      jcyc = 0;
      #1;
      check("R1 tick after release", tick_o, 0);
      run(100);

      // R3: directed fractional and integer ratios
      wr(A_CFG, 32'h0000_043F); run(300);
      wr(A_CFG, 32'h0000_045F); run(300);
      wr(A_CFG, 32'h0000_04BF); run(500);
      wr(A_CFG, 32'h0000_000C); run(60);
      wr(A_CFG, 32'h0000_0019); run(60);
      wr(A_CFG, 32'h0000_002F); run(120);
      // R2: upper write bits discarded
      wr(A_CFG, 32'hDEAD_000B); run(50);
      // R7: ignored writes to counter and unused address
      wr(A_CNT, 32'h0000_0055); run(30);
      wr(8'h20, 32'h0000_0101); run(30);
      addr = 8'h20; #1;
      check("R7 unmapped read zero", rdata, 0);
      addr = A_CNT;
      // R6: divide by one and saturated ratios; R4 wrap via 8-bit counter
      wr(A_CFG, 32'h0000_0000); run(300);
      wr(A_CFG, 32'h0000_0100); run(40);
      wr(A_CFG, 32'h0000_FF00); run(40);
      wr(A_CFG, 32'h0000_FFFF); run(40);
      // seeded random ratios, mostly N < D
      for (int k = 0; k < 10; k++) begin
         lo = 8'($urandom());
         hi = (k % 4 == 3) ? 8'($urandom()) : 8'($urandom() % (32'(lo) + 1));
         wr(A_CFG, {16'h0, hi, lo});
         run(400);
      end
      // R5: rewrite mid-phase restarts the staircase
      wr(A_CFG, 32'h0000_043F); run(17);
      wr(A_CFG, 32'h0000_043F); run(100);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule